// File: doc/BRIEF.md
# Frame-to-Cell Ingress Header Mapper

The block sits between the ingress frame FIFO of a switch interface and a fabric cell transmitter. It reads variable-length frames held as 32-bit words, each frame's first word flagged by a start-of-frame bit, and turns every unicast or multicast-ID frame into one fixed-length fabric cell. Each cell has an 11-byte header built from the frame's header fields. The whole frame follows it byte for byte, and the cell ends with zero padding. Idle frames and unsupported frame types are dropped.

When the FIFO holds nothing at a cell boundary, the block sends an idle cell, so the fabric always receives backpressure information. Every cell carries an egress-backpressure bit. That bit is set when a ready input is low or when an outbound FIFO is above its high watermark. The cell stream leaves one byte per cycle with a start strobe. If the FIFO runs dry inside a frame, the stream pauses with its valid strobe low. The cell payload length is a synthesis parameter of 64, 72 or 80 bytes. The largest frame payload that fits is 8 bytes less.

Top module: `framecell_mapper`

## Requirements
- R1: The FIFO is read (fifo_rd_o) only while fifo_empty_i is low. A word with fifo_sof_i high starts a frame. Between frames, any word without fifo_sof_i is read and discarded. Frame byte 0 is word bits [31:24] and byte 3 is bits [7:0], so bytes are taken most significant first.
- R2: Frame byte 0 bits [5:2] hold the type, where 1 means unicast. A unicast frame gives a cell with MC=0 and a 20-bit tag equal to {10'b0, destination[9:0]}. The destination is {byte4[3:0], byte5}.
- R3: Type 2 is multicast-ID. It gives a cell with MC=1 and a tag equal to the low 20 bits of the multicast ID. The multicast ID is {byte3[5:0], byte4, byte5}.
- R4: Cell byte 0 is {0, EBP, TRCLASS[2:0], MC, PSW, 0}. Cell byte 1 is 0. Cell bytes 2..4 are {4'b0, tag[19:16]}, tag[15:8] and tag[7:0]. TRCLASS is frame byte 2 bits [7:5]. PSW is psw_id_i.
- R5: EBP is 1 when crdy_i or drdy_i is low, or when od_hi_i or oc_hi_i is high; otherwise it is 0. For a data cell the inputs are sampled when the frame's second word is read. For an idle cell they are sampled when that cell is started.
- R6: Frames of type 0 (idle) and of any type other than 1 or 2 produce no cell.
- R7: If the FIFO is empty at a cell boundary, an idle cell is sent. It has TRCLASS=111, MC=0, tag 0, EBP by R5, PSW by R4, and all other bytes 0.
- R8: A cell is 11+CELL_PAYLOAD bytes long. Bytes 5..10 are 0. Frame byte i goes to cell byte 11+i. The frame length is byte1 + 8.
- R9: Cell bytes after the copied frame are 0x00, including any bytes in the frame's last word beyond its length.
- R10: A frame whose payload length (byte 1) exceeds CELL_PAYLOAD-8 is cut to CELL_PAYLOAD bytes, and its leftover words are discarded. frame_trunc_o pulses together with that cell's start strobe.
- R11: Bytes leave one per cycle with cell_valid_o high, and cell_sof_o marks byte 0. If the FIFO empties inside a frame, cell_valid_o stays low until data returns. During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_data_i | input | 32 | Head word of the ingress FIFO |
| fifo_sof_i | input | 1 | Head word starts a frame |
| fifo_empty_i | input | 1 | Ingress FIFO empty |
| fifo_rd_o | output | 1 | Pop the head word |
| crdy_i | input | 1 | Control-queue ready |
| drdy_i | input | 1 | Data-queue ready |
| od_hi_i | input | 1 | Outbound data FIFO above high watermark |
| oc_hi_i | input | 1 | Outbound control FIFO above high watermark |
| psw_id_i | input | 1 | Provisioned switch-ID bit |
| cell_byte_o | output | 8 | Cell byte |
| cell_valid_o | output | 1 | cell_byte_o is valid |
| cell_sof_o | output | 1 | First byte of a cell |
| frame_trunc_o | output | 1 | Current cell holds a cut-down frame |

## Verification
The bench checks a frame with a payload length that is not a multiple of four. A design that copied whole words would leak the filler bytes of the last word into the pad area. It checks a frame that exactly fills the cell and one that is too long. A cut-down frame that is handled wrongly either overruns the cell or leaves its remainder to corrupt the next frame, which is checked right after it. Stray non-start words, idle frames and unknown types are fed just ahead of a good frame: a mapper that parsed them would emit extra cells or shift the good one. The bench also starves the FIFO in the middle of a frame, and a design that padded instead of pausing there would produce a cell of the wrong content.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  localparam int HDR_BYTES = 11;
  localparam int FRM_OVH   = 8;
  localparam int LW        = 9;
  localparam int HIW       = 4;

  localparam logic [3:0] FT_UNI  = 4'd1;
  localparam logic [3:0] FT_MCID = 4'd2;

  typedef enum logic [1:0] {S_ARB, S_W1, S_CELL} seq_st_e;

  typedef struct packed {
    logic        ebp;
    logic [2:0]  trc;
    logic        mc;
    logic        psw;
    logic [19:0] tag;
  } cell_hdr_t;

  function automatic logic [7:0] word_byte(input logic [31:0] w, input logic [1:0] i);
    case (i)
      2'd0:    return w[31:24];
      2'd1:    return w[23:16];
      2'd2:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction
endpackage

// File: rtl/fcm_len_dec.sv
module fcm_len_dec
  import fcm_pkg::*;
#(
  parameter int CELL_PAYLOAD = 64
) (
  input  logic [31:0]   word_i,
  output logic          ok_o,
  output logic [LW-1:0] len_o,
  output logic          trunc_o
);
  localparam int MAX_PAY = CELL_PAYLOAD - FRM_OVH;

  logic [3:0]    ftype;
  logic [7:0]    pay_len;
  logic [LW-1:0] full_len;

  assign ftype    = word_i[29:26];
  assign pay_len  = word_i[23:16];
  assign full_len = LW'(pay_len) + LW'(FRM_OVH);
  assign ok_o     = (ftype == FT_UNI) || (ftype == FT_MCID);
  assign trunc_o  = LW'(pay_len) > LW'(MAX_PAY);
  assign len_o    = trunc_o ? LW'(CELL_PAYLOAD) : full_len;

  logic unused_bits;
  assign unused_bits = ^{word_i[31:30], word_i[25:24], word_i[15:0]};
endmodule

// File: rtl/fcm_hdr_build.sv
module fcm_hdr_build
  import fcm_pkg::*;
(
  input  logic [31:0] w0_i,
  input  logic [31:0] w1_i,
  input  logic        idle_i,
  input  logic        crdy_i,
  input  logic        drdy_i,
  input  logic        od_hi_i,
  input  logic        oc_hi_i,
  input  logic        psw_i,
  output cell_hdr_t   hdr_o
);
  logic is_mc;
  assign is_mc = (w0_i[29:26] == FT_MCID);

  always_comb begin
    hdr_o.ebp = !crdy_i || !drdy_i || od_hi_i || oc_hi_i;
    hdr_o.psw = psw_i;
    if (idle_i) begin
      hdr_o.trc = 3'b111;
      hdr_o.mc  = 1'b0;
      hdr_o.tag = '0;
    end else begin
      hdr_o.trc = w0_i[15:13];
      hdr_o.mc  = is_mc;
      hdr_o.tag = is_mc ? {w0_i[3:0], w1_i[31:16]} : {10'd0, w1_i[25:16]};
    end
  end

  logic unused_bits;
  assign unused_bits = ^{w0_i[31:30], w0_i[25:16], w0_i[12:4], w1_i[15:0]};
endmodule

// File: rtl/fcm_hdr_ser.sv
module fcm_hdr_ser
  import fcm_pkg::*;
(
  input  cell_hdr_t      hdr_i,
  input  logic [HIW-1:0] sel_i,
  output logic [7:0]     byte_o
);
  localparam int SLOTS = 1 << HIW;

  logic [7:0] slot [SLOTS];

  assign slot[0] = {1'b0, hdr_i.ebp, hdr_i.trc, hdr_i.mc, hdr_i.psw, 1'b0};
  assign slot[1] = 8'h00;
  assign slot[2] = {4'h0, hdr_i.tag[19:16]};
  assign slot[3] = hdr_i.tag[15:8];
  assign slot[4] = hdr_i.tag[7:0];

  // reserved header bytes and unused slots
  for (genvar g = 5; g < SLOTS; g++) begin : g_zero
    assign slot[g] = 8'h00;
  end

  assign byte_o = slot[sel_i];
endmodule

// File: rtl/fcm_seq.sv
module fcm_seq
  import fcm_pkg::*;
#(
  parameter int CELL_PAYLOAD = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [31:0]    fifo_data_i,
  input  logic           fifo_sof_i,
  input  logic           fifo_empty_i,
  output logic           fifo_rd_o,
  input  logic           frm_ok_i,
  input  logic [LW-1:0]  frm_len_i,
  input  logic           frm_trunc_i,
  input  cell_hdr_t      hdr_i,
  input  logic [7:0]     hdr_byte_i,
  output logic [31:0]    w0_o,
  output logic           idle_sel_o,
  output cell_hdr_t      hdr_o,
  output logic [HIW-1:0] hsel_o,
  output logic [7:0]     cell_byte_o,
  output logic           cell_valid_o,
  output logic           cell_sof_o,
  output logic           frame_trunc_o
);
  localparam int CELL_BYTES = HDR_BYTES + CELL_PAYLOAD;
  localparam int PW         = $clog2(CELL_BYTES);

  seq_st_e       state_q, state_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [31:0]   w0_q, w0_d, w1_q, w1_d, cur_q, cur_d;
  logic [LW-1:0] flen_q, flen_d;
  logic          ftr_q, ftr_d;
  cell_hdr_t     hdr_q, hdr_d;
  logic          rd, emit;
  logic [7:0]    byte_n;
  logic [LW-1:0] kk;

  assign kk = LW'(pos_q) - LW'(HDR_BYTES);

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    w0_d    = w0_q;
    w1_d    = w1_q;
    cur_d   = cur_q;
    flen_d  = flen_q;
    ftr_d   = ftr_q;
    hdr_d   = hdr_q;
    rd      = 1'b0;
    emit    = 1'b0;
    byte_n  = 8'h00;
    unique case (state_q)
      S_ARB: begin
        if (!fifo_empty_i) begin
          rd = 1'b1;  // stray or unsupported words are popped and dropped
          if (fifo_sof_i && frm_ok_i) begin
            w0_d    = fifo_data_i;
            flen_d  = frm_len_i;
            ftr_d   = frm_trunc_i;
            state_d = S_W1;
          end
        end else begin
          hdr_d   = hdr_i;
          flen_d  = '0;
          ftr_d   = 1'b0;
          pos_d   = '0;
          state_d = S_CELL;
        end
      end
      S_W1: begin
        if (!fifo_empty_i) begin
          rd      = 1'b1;
          w1_d    = fifo_data_i;
          hdr_d   = hdr_i;
          pos_d   = '0;
          state_d = S_CELL;
        end
      end
      S_CELL: begin
        emit = 1'b1;
        if (pos_q < PW'(HDR_BYTES)) begin
          byte_n = hdr_byte_i;
        end else if (kk < flen_q) begin
          if (kk < LW'(4)) begin
            byte_n = word_byte(w0_q, kk[1:0]);
          end else if (kk < LW'(8)) begin
            byte_n = word_byte(w1_q, kk[1:0]);
          end else if (kk[1:0] == 2'd0) begin
            if (fifo_empty_i) begin
              emit = 1'b0;
            end else begin
              rd     = 1'b1;
              cur_d  = fifo_data_i;
              byte_n = fifo_data_i[31:24];
            end
          end else begin
            byte_n = word_byte(cur_q, kk[1:0]);
          end
        end
        if (emit) begin
          if (pos_q == PW'(CELL_BYTES - 1)) state_d = S_ARB;
          else                              pos_d   = pos_q + 1'b1;
        end
      end
      default: state_d = S_ARB;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= S_ARB;
      pos_q         <= '0;
      w0_q          <= '0;
      w1_q          <= '0;
      cur_q         <= '0;
      flen_q        <= '0;
      ftr_q         <= 1'b0;
      hdr_q         <= '0;
      cell_byte_o   <= 8'h00;
      cell_valid_o  <= 1'b0;
      cell_sof_o    <= 1'b0;
      frame_trunc_o <= 1'b0;
    end else begin
      state_q       <= state_d;
      pos_q         <= pos_d;
      w0_q          <= w0_d;
      w1_q          <= w1_d;
      cur_q         <= cur_d;
      flen_q        <= flen_d;
      ftr_q         <= ftr_d;
      hdr_q         <= hdr_d;
      cell_byte_o   <= emit ? byte_n : 8'h00;
      cell_valid_o  <= emit;
      cell_sof_o    <= emit && (pos_q == '0);
      frame_trunc_o <= emit && (pos_q == '0) && ftr_q;
    end
  end

  assign fifo_rd_o  = rd;
  assign w0_o       = w0_q;
  assign idle_sel_o = (state_q == S_ARB);
  assign hdr_o      = hdr_q;
  assign hsel_o     = pos_q[HIW-1:0];

  // R1
  rd_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> !fifo_empty_i);
endmodule

// File: rtl/framecell_mapper.sv
module framecell_mapper
  import fcm_pkg::*;
#(
  parameter int CELL_PAYLOAD = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] fifo_data_i,
  input  logic        fifo_sof_i,
  input  logic        fifo_empty_i,
  output logic        fifo_rd_o,
  input  logic        crdy_i,
  input  logic        drdy_i,
  input  logic        od_hi_i,
  input  logic        oc_hi_i,
  input  logic        psw_id_i,
  output logic [7:0]  cell_byte_o,
  output logic        cell_valid_o,
  output logic        cell_sof_o,
  output logic        frame_trunc_o
);
  localparam int CELL_BYTES = HDR_BYTES + CELL_PAYLOAD;
  localparam int PW         = $clog2(CELL_BYTES);

  logic           frm_ok, frm_trunc, idle_sel;
  logic [LW-1:0]  frm_len;
  logic [31:0]    w0;
  cell_hdr_t      hdr_new, hdr_cur;
  logic [HIW-1:0] hsel;
  logic [7:0]     hdr_byte;

  fcm_len_dec #(.CELL_PAYLOAD(CELL_PAYLOAD)) u_len (
    .word_i (fifo_data_i),
    .ok_o   (frm_ok),
    .len_o  (frm_len),
    .trunc_o(frm_trunc)
  );

  fcm_hdr_build u_build (
    .w0_i   (w0),
    .w1_i   (fifo_data_i),
    .idle_i (idle_sel),
    .crdy_i (crdy_i),
    .drdy_i (drdy_i),
    .od_hi_i(od_hi_i),
    .oc_hi_i(oc_hi_i),
    .psw_i  (psw_id_i),
    .hdr_o  (hdr_new)
  );

  fcm_hdr_ser u_ser (
    .hdr_i (hdr_cur),
    .sel_i (hsel),
    .byte_o(hdr_byte)
  );

  fcm_seq #(.CELL_PAYLOAD(CELL_PAYLOAD)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_data_i  (fifo_data_i),
    .fifo_sof_i   (fifo_sof_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_rd_o    (fifo_rd_o),
    .frm_ok_i     (frm_ok),
    .frm_len_i    (frm_len),
    .frm_trunc_i  (frm_trunc),
    .hdr_i        (hdr_new),
    .hdr_byte_i   (hdr_byte),
    .w0_o         (w0),
    .idle_sel_o   (idle_sel),
    .hdr_o        (hdr_cur),
    .hsel_o       (hsel),
    .cell_byte_o  (cell_byte_o),
    .cell_valid_o (cell_valid_o),
    .cell_sof_o   (cell_sof_o),
    .frame_trunc_o(frame_trunc_o)
  );

  // byte count of the cell in flight, for the length check
  logic [PW:0] acnt;
  logic        astarted;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acnt     <= '0;
      astarted <= 1'b0;
    end else if (cell_sof_o) begin
      acnt     <= (PW+1)'(1);
      astarted <= 1'b1;
    end else if (cell_valid_o) begin
      acnt     <= acnt + 1'b1;
    end
  end

  // R8
  cell_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_sof_o && astarted) |-> (acnt == (PW+1)'(CELL_BYTES)));

  // R11
  no_orphan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_valid_o && !cell_sof_o) |-> astarted);

  // R10
  trunc_sof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_trunc_o |-> cell_sof_o);

  // R4
  res_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_sof_o |-> (!cell_byte_o[7] && !cell_byte_o[0]));
endmodule

// File: tb/framecell_mapper_test.sv
module framecell_mapper_test;
  localparam int CLK_PERIOD = 10;
  localparam int CP   = 64;
  localparam int CB   = 11 + CP;
  localparam int MAXP = CP - 8;

  typedef logic [CB*8-1:0] cell_t;
  typedef struct packed {
    logic [3:0]  typ;
    logic [7:0]  cls;
    logic [21:0] addr;
    logic [7:0]  len;
    logic        crdy, drdy, odh, och, psw;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 8'hA3, 22'h000FFF, 8'd20, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd2, 8'h47, 22'h3ABCDE, 8'd56, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{4'd1, 8'h1F, 22'h0005A5, 8'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd1, 8'hE0, 22'h000123, 8'd33, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{4'd1, 8'h80, 22'h000321, 8'd70, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd2, 8'h60, 22'h000001, 8'd9,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] fifo_data = '0;
  logic fifo_sof = 1'b0, fifo_empty = 1'b1, fifo_rd;
  logic crdy = 1'b1, drdy = 1'b1, odh = 1'b0, och = 1'b0, psw = 1'b1;
  logic [7:0] cell_byte;
  logic cell_valid, cell_sof, frame_trunc;

  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  framecell_mapper #(.CELL_PAYLOAD(CP)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .fifo_data_i(fifo_data), .fifo_sof_i(fifo_sof), .fifo_empty_i(fifo_empty),
    .fifo_rd_o(fifo_rd),
    .crdy_i(crdy), .drdy_i(drdy), .od_hi_i(odh), .oc_hi_i(och), .psw_id_i(psw),
    .cell_byte_o(cell_byte), .cell_valid_o(cell_valid), .cell_sof_o(cell_sof),
    .frame_trunc_o(frame_trunc)
  );

  // FIFO model: pop on the edge, present the head at the falling edge
  logic [32:0] fq [$];
  always @(posedge clk) if (fifo_rd && fq.size() > 0) void'(fq.pop_front());
  always @(negedge clk) begin
    fifo_empty <= (fq.size() == 0);
    fifo_data  <= (fq.size() > 0) ? fq[0][31:0] : 32'h0;
    fifo_sof   <= (fq.size() > 0) ? fq[0][32] : 1'b0;
  end

  // cell monitor
  cell_t cbuf, last_idle;
  int    cidx = 0, idle_cnt = 0;
  logic  ctr;
  cell_t dq [$];
  logic  tq [$];
  always @(negedge clk) begin
    if (rst_n && cell_valid) begin
      if (cell_sof) begin cidx = 0; ctr = frame_trunc; cbuf = '0; end
      if (cidx < CB) begin cbuf[cidx*8 +: 8] = cell_byte; cidx++; end
      if (cidx == CB) begin
        if (cbuf[11*8 +: 8] != 8'h00) begin dq.push_back(cbuf); tq.push_back(ctr); end
        else begin last_idle = cbuf; idle_cnt++; end
        cidx = CB + 1;
      end
    end
  end

  logic [7:0] fb [0:271];
  int fbl;

  task automatic build(input logic [3:0] typ, input logic [7:0] cls, input logic [21:0] addr,
                       input int len, input int seed);
    fbl   = len + 8;
    fb[0] = {2'b11, typ, 2'b00};
    fb[1] = len[7:0];
    fb[2] = cls;
    fb[3] = (typ == 4'd2) ? {2'b00, addr[21:16]} : 8'h00;
    fb[4] = (typ == 4'd2) ? addr[15:8] : {4'h0, addr[11:8]};
    fb[5] = addr[7:0];
    for (int i = 0; i < len; i++) fb[6+i] = 8'((seed + i*13) & 8'hFF);
    fb[6+len] = 8'hA5;
    fb[7+len] = 8'h5A;
  endtask

  task automatic push_words(input int first, input int last);
    for (int w = first; w <= last; w++) begin
      logic [31:0] wd;
      for (int b = 0; b < 4; b++)
        wd[31-8*b -: 8] = (4*w + b < fbl) ? fb[4*w+b] : 8'hEE;
      fq.push_back({(w == 0), wd});
    end
  endtask

  function automatic int nwords();
    return (fbl + 3) / 4;
  endfunction

  function automatic cell_t exp_cell(input logic [3:0] typ, input logic [7:0] cls,
                                     input logic [21:0] addr, input logic ebp, input logic p);
    cell_t c = '0;
    logic [19:0] tag = (typ == 4'd2) ? addr[19:0] : {10'd0, addr[9:0]};
    int n = (fbl < CP) ? fbl : CP;
    c[7:0]   = {1'b0, ebp, cls[7:5], (typ == 4'd2), p, 1'b0};
    c[23:16] = {4'h0, tag[19:16]};
    c[31:24] = tag[15:8];
    c[39:32] = tag[7:0];
    for (int i = 0; i < n; i++) c[(11+i)*8 +: 8] = fb[i];
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_cell(input cell_t a, input cell_t e, input string req);
    int bad = -1;
    for (int i = CB - 1; i >= 0; i--) if (a[i*8 +: 8] !== e[i*8 +: 8]) bad = i;
    if (bad < 0) chk(1'b1, req, "cell", 0, 0);
    else chk(1'b0, req, $sformatf("cell byte %0d", bad), 64'(a[bad*8 +: 8]), 64'(e[bad*8 +: 8]));
  endtask

  task automatic get_cell(output cell_t c, output logic t);
    int w = 0;
    while (dq.size() == 0 && w < 3000) begin @(negedge clk); w++; end
    if (dq.size() == 0) begin
      chk(1'b0, "R8", "no data cell", 0, 1);
      c = '0; t = 1'b0;
    end else begin
      c = dq.pop_front(); t = tq.pop_front();
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    cell_t c, e;
    logic  t;
    int    n0, lowcnt;

    // reset state (R11)
    repeat (3) @(negedge clk);
    chk(!cell_valid && !cell_sof && !frame_trunc && !fifo_rd && cell_byte == 8'h00,
        "R11", "reset outputs", {cell_valid, cell_sof, frame_trunc, fifo_rd, cell_byte}, 0);
    rst_n = 1'b1;

    // idle cell with clear backpressure (R7)
    while (idle_cnt < 1) @(negedge clk);
    e = '0; e[7:0] = 8'h3A;
    cmp_cell(last_idle, e, "R7 idle cell");

    // idle cell with control watermark high (R5 R7)
    och = 1'b1;
    n0 = idle_cnt;
    while (idle_cnt < n0 + 2) @(negedge clk);
    chk(last_idle[7:0] == 8'h7A, "R5 R7", "idle ebp byte", 64'(last_idle[7:0]), 64'h7A);
    och = 1'b0;

    // mapping table (R2 R3 R4 R5 R8 R9 R10)
    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      @(negedge clk);
      crdy = v.crdy; drdy = v.drdy; odh = v.odh; och = v.och; psw = v.psw;
      build(v.typ, v.cls, v.addr, int'(v.len), 17 * i + 3);
      push_words(0, nwords() - 1);
      get_cell(c, t);
      e = exp_cell(v.typ, v.cls, v.addr, !v.crdy || !v.drdy || v.odh || v.och, v.psw);
      cmp_cell(c, e, (v.typ == 4'd2) ? "R3 R4 R5 R8 R9" : "R2 R4 R5 R8 R9");
      chk(t == (v.len > MAXP), "R10", $sformatf("trunc flag vec %0d", i), 64'(t), 64'(v.len > MAXP));
    end
    crdy = 1'b1; drdy = 1'b1; odh = 1'b0; och = 1'b0; psw = 1'b0;

    // stray words, idle frame and unknown type ahead of a good frame (R1 R6)
    @(negedge clk);
    fq.push_back({1'b0, 32'hDEAD_BEEF});
    build(4'd0, 8'hFF, 22'h0, 0, 1);
    push_words(0, nwords() - 1);
    build(4'd3, 8'hFF, 22'h3FFFFF, 0, 1);
    push_words(0, nwords() - 1);
    fq.push_back({1'b0, 32'hCAFE_0001});
    build(4'd1, 8'h25, 22'h0002AB, 12, 99);
    push_words(0, nwords() - 1);
    get_cell(c, t);
    e = exp_cell(4'd1, 8'h25, 22'h0002AB, 1'b0, 1'b0);
    cmp_cell(c, e, "R1 R6 dropped frames");
    repeat (300) @(negedge clk);
    chk(dq.size() == 0, "R6", "extra data cells", 64'(dq.size()), 0);

    // FIFO runs dry mid-frame (R11)
    build(4'd2, 8'hC1, 22'h155555, 40, 7);
    push_words(0, 3);
    repeat (300) @(negedge clk);
    lowcnt = 0;
    for (int k = 0; k < 5; k++) begin @(negedge clk); if (!cell_valid) lowcnt++; end
    chk(lowcnt == 5, "R11", "valid during stall", 64'(lowcnt), 5);
    chk(dq.size() == 0, "R11", "cell done early", 64'(dq.size()), 0);
    push_words(4, nwords() - 1);
    get_cell(c, t);
    e = exp_cell(4'd2, 8'hC1, 22'h155555, 1'b0, 1'b0);
    cmp_cell(c, e, "R11 R9 stalled cell");

    summary();
    $finish;
  end
endmodule